// File: doc/BRIEF.md
# LIN Slave Baud Rate Measurement

This block times the sync byte that a LIN slave receives from the master and turns the measured span into a per-bit baud divisor for the receiver. Once the slave state machine pulses `arm_i`, the next falling edge on the synchronised receive line starts a cycle counter. The fourth falling edge after that one ends the count, which then covers eight bit times of the 0x55 sync byte. The count is divided by eight with rounding and loaded as the new divisor.

Completion is reported through a sticky flag that can raise an interrupt. If the counter runs past its range before the closing edge arrives, the block does not load a divisor. It sets the shared error flag and also marks the measurement as complete. The same error flag records ordinary receive-data overruns coming from the UART datapath. Each flag is cleared by a read strobe for its own register, and a set in the same cycle as a clearing read takes priority over the clear.

Top module: `lin_autobaud`

## Requirements
- R1: After reset `divisor_o` equals the parameter `DIV_RST` (default 16), and `done_o`, `err_o` and `irq_o` are 0.
- R2: The span is the number of clock cycles from the start-bit falling edge to the 4th later falling edge. On a valid completion, `divisor_o` loads (span + 4) >> 3. At all other times `divisor_o` holds its value.
- R3: In slave mode, a completed measurement sets `done_o` one clock after the closing falling edge is sampled.
- R4: `irq_o` is 1 exactly when `done_o` is 1 and `irq_en_i` is 1.
- R5: The measurement counter is 16 bits wide. If 65536 cycles pass after the start edge with no closing edge, the counter overflows. On overflow `err_o` and `done_o` both set, `divisor_o` keeps its previous value, and the block returns to idle.
- R6: A `rd_stat_i` pulse clears `done_o` and leaves `err_o` unchanged. A `rd_data_i` pulse clears `err_o`.
- R7: While `slave_mode_i` is 0, `done_o` and `irq_o` read 0, and arming and measuring do not happen.
- R8: Falling edges seen before an arm pulse are ignored, and the divisor and flags stay unchanged.
- R9: If a flag's set event and its clearing read fall in the same cycle, the flag ends up set.
- R10: A pulse on `rx_ovr_i` sets `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronised receive line |
| slave_mode_i | input | 1 | 1 = LIN slave, 0 = master |
| arm_i | input | 1 | Strobe that enables one measurement |
| irq_en_i | input | 1 | Autobaud interrupt enable |
| rd_stat_i | input | 1 | Status register read strobe |
| rd_data_i | input | 1 | Receive data register read strobe |
| rx_ovr_i | input | 1 | Ordinary receive overrun event from the datapath |
| divisor_o | output | 16 | Per-bit baud divisor |
| done_o | output | 1 | Autobaud complete flag |
| err_o | output | 1 | Overrun / autobaud error flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A flag can be set and cleared by its own read strobe in the same cycle. This happens when the closing sync edge lands together with a status read, and when a datapath overrun pulse lands together with a data read. The bench produces both cases by driving the read strobe on the same negative edge as the event. It then expects the flag to read 1 on the following cycle, followed by a 0 after a separate, lone read.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } ab_state_e;
endpackage

// File: rtl/lin_ab_edge.sv
module lin_ab_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/lin_ab_timer.sv
module lin_ab_timer
  import lin_ab_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SYNC_FALLS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             slave_mode_i,
  input  logic             arm_i,
  output logic             ok_o,
  output logic             ovf_o,
  output logic [CNT_W:0]   span_o
);
  localparam int FW = $clog2(SYNC_FALLS + 1);
  localparam logic [FW-1:0] LAST = FW'(SYNC_FALLS - 1);

  ab_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FW-1:0]    nf_q, nf_d;
  logic [CNT_W:0]   inc;
  logic             final_edge, live;

  assign inc        = {1'b0, cnt_q} + 1'b1;
  assign live       = slave_mode_i & ~arm_i & (st_q == ST_MEAS);
  assign final_edge = fall_i & (nf_q == LAST);
  assign ok_o       = live & final_edge;
  assign ovf_o      = live & ~final_edge & inc[CNT_W];
  assign span_o     = inc;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    nf_d  = nf_q;
    if (!slave_mode_i) begin
      st_d = ST_IDLE;
    end else if (arm_i) begin
      st_d = ST_ARMED;
    end else begin
      unique case (st_q)
        ST_ARMED: if (fall_i) begin
          st_d  = ST_MEAS;
          cnt_d = '0;
          nf_d  = '0;
        end
        ST_MEAS: begin
          cnt_d = inc[CNT_W-1:0];
          if (ok_o || ovf_o) st_d = ST_IDLE;
          else if (fall_i)   nf_d = nf_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      nf_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      nf_q  <= nf_d;
    end
  end
endmodule

// File: rtl/lin_ab_div.sv
module lin_ab_div #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] DIV_RST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W:0]   span_i,
  output logic [CNT_W-1:0] div_o
);
  localparam int SW = CNT_W + 2;
  logic [SW-1:0] sum;

  // round to nearest: (span + 4) / 8
  assign sum = {1'b0, span_i} + SW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_o <= DIV_RST;
    else if (load_i) div_o <= CNT_W'(sum >> 3);
  end
endmodule

// File: rtl/lin_ab_flags.sv
module lin_ab_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_set_i,
  input  logic err_set_i,
  input  logic rd_stat_i,
  input  logic rd_data_i,
  input  logic slave_mode_i,
  input  logic irq_en_i,
  output logic done_o,
  output logic err_o,
  output logic irq_o
);
  logic done_q, err_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (done_set_i)     done_q <= 1'b1;
      else if (rd_stat_i) done_q <= 1'b0;
      if (err_set_i)      err_q  <= 1'b1;
      else if (rd_data_i) err_q  <= 1'b0;
    end
  end

  assign done_o = done_q & slave_mode_i;
  assign err_o  = err_q;
  assign irq_o  = done_o & irq_en_i;
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int               CNT_W      = 16,
  parameter int               SYNC_FALLS = 4,
  parameter logic [CNT_W-1:0] DIV_RST    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             slave_mode_i,
  input  logic             arm_i,
  input  logic             irq_en_i,
  input  logic             rd_stat_i,
  input  logic             rd_data_i,
  input  logic             rx_ovr_i,
  output logic [CNT_W-1:0] divisor_o,
  output logic             done_o,
  output logic             err_o,
  output logic             irq_o
);
  logic           fall, meas_ok, meas_ovf, done_set, err_set;
  logic [CNT_W:0] span;

  assign done_set = meas_ok | meas_ovf;
  assign err_set  = meas_ovf | rx_ovr_i;

  lin_ab_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .fall_o(fall)
  );

  lin_ab_timer #(.CNT_W(CNT_W), .SYNC_FALLS(SYNC_FALLS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall),
    .slave_mode_i(slave_mode_i),
    .arm_i       (arm_i),
    .ok_o        (meas_ok),
    .ovf_o       (meas_ovf),
    .span_o      (span)
  );

  lin_ab_div #(.CNT_W(CNT_W), .DIV_RST(DIV_RST)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(meas_ok),
    .span_i(span),
    .div_o (divisor_o)
  );

  lin_ab_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_set_i  (done_set),
    .err_set_i   (err_set),
    .rd_stat_i   (rd_stat_i),
    .rd_data_i   (rd_data_i),
    .slave_mode_i(slave_mode_i),
    .irq_en_i    (irq_en_i),
    .done_o      (done_o),
    .err_o       (err_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slave_mode_i,
  input logic             rd_stat_i,
  input logic             rd_data_i,
  input logic             done_set,
  input logic             err_set,
  input logic [CNT_W-1:0] divisor_o,
  input logic             done_o,
  input logic             err_o,
  input logic             irq_o
);
  assert_div_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_set |=> $stable(divisor_o));
  assert_irq_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  assert_err_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set |=> err_o);
  assert_stat_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat_i && !done_set |=> !done_o);
  assert_data_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !err_set |=> !err_o);
  assert_master_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_mode_i |-> !done_o && !irq_o);
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set && rd_stat_i |=> done_o || !slave_mode_i);
endmodule

bind lin_autobaud lin_autobaud_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/lin_autobaud_tb_top.sv
`timescale 1ns/1ps
module lin_autobaud_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        rx_i = 1'b1, slave_mode_i = 1'b1, arm_i = 1'b0, irq_en_i = 1'b0;
  logic        rd_stat_i = 1'b0, rd_data_i = 1'b0, rx_ovr_i = 1'b0;
  logic [15:0] divisor_o;
  logic        done_o, err_o, irq_o;
  int          n_chk = 0, n_err = 0;
  logic [15:0] cur_div;

  always #2 clk_i = ~clk_i;

  lin_autobaud dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_div(int span);
    return (span + 4) >> 3;
  endfunction

  // line level k cycles after the start edge; falls at 0,2b,4b,6b,s
  function automatic logic lvl(int k, int b, int s);
    int h = 6 * b + (s - 6 * b) / 2;
    if (k < 6 * b) return logic'((k / b) % 2);
    if (k < h) return 1'b0;
    if (k < s) return 1'b1;
    if (k < s + b) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic arm();
    @(negedge clk_i) arm_i = 1'b1;
    @(negedge clk_i) arm_i = 1'b0;
  endtask

  // rd_at_end: status read in the cycle of the closing edge
  task automatic send_sync(int b, int s, bit rd_at_end);
    for (int k = 0; k <= s + 2 * b; k++) begin
      @(negedge clk_i);
      rx_i = lvl(k, b, s);
      rd_stat_i = rd_at_end && (k == s);
    end
    rd_stat_i = 1'b0;
    cyc(2);
  endtask

  task automatic pulse_stat();
    @(negedge clk_i) rd_stat_i = 1'b1;
    @(negedge clk_i) rd_stat_i = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk_i) rd_data_i = 1'b1;
    @(negedge clk_i) rd_data_i = 1'b0;
  endtask

  initial begin
    #(4ns * 200000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    chk("R1 div", divisor_o, 16);
    chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_ni = 1'b1;
    cyc(2);
    cur_div = divisor_o;

    // R8: no arm -> ignored
    send_sync(10, 80, 1'b0);
    chk("R8 div", divisor_o, cur_div);
    chk("R8 done", done_o, 0);

    // R2/R3/R4 random
    for (int i = 0; i < 16; i++) begin
      int b = $urandom_range(40, 2);
      int s = $urandom_range(9 * b, 6 * b + 2);
      bit en = 1'($urandom_range(1, 0));
      irq_en_i = en;
      arm();
      cyc($urandom_range(5, 1));
      send_sync(b, s, 1'b0);
      chk("R2 div", divisor_o, exp_div(s));
      chk("R3 done", done_o, 1);
      chk("R4 irq", irq_o, int'(en));
      chk("R2 err", err_o, 0);
      pulse_stat();
      chk("R6 done clr", done_o, 0);
      chk("R4 irq clr", irq_o, 0);
    end
    cur_div = divisor_o;

    // R9: closing edge with status read
    irq_en_i = 1'b1;
    arm();
    send_sync(12, 96, 1'b1);
    chk("R9 done wins", done_o, 1);
    chk("R2 div 12", divisor_o, 12);
    pulse_stat();
    chk("R9 later clr", done_o, 0);
    cur_div = divisor_o;

    // R5: overflow
    arm();
    @(negedge clk_i) rx_i = 1'b0;
    cyc(66000);
    rx_i = 1'b1;
    cyc(2);
    chk("R5 err", err_o, 1);
    chk("R5 done", done_o, 1);
    chk("R5 div kept", divisor_o, cur_div);
    pulse_stat();
    chk("R6 stat keeps err", err_o, 1);
    send_sync(8, 64, 1'b0);
    chk("R5 idle after ovf", done_o, 0);
    pulse_data();
    chk("R6 err clr", err_o, 0);

    // R10 + R9 on err
    @(negedge clk_i) begin rx_ovr_i = 1'b1; rd_data_i = 1'b1; end
    @(negedge clk_i) begin rx_ovr_i = 1'b0; rd_data_i = 1'b0; end
    chk("R10/R9 err", err_o, 1);
    pulse_data();
    chk("R6 err clr2", err_o, 0);

    // R7: master mode
    arm();
    send_sync(6, 48, 1'b0);
    chk("R7 pre done", done_o, 1);
    slave_mode_i = 1'b0;
    cyc(1);
    chk("R7 done zero", done_o, 0);
    chk("R7 irq zero", irq_o, 0);
    slave_mode_i = 1'b1;
    pulse_stat();
    slave_mode_i = 1'b0;
    cur_div = divisor_o;
    arm();
    send_sync(20, 160, 1'b0);
    chk("R7 no measure", divisor_o, cur_div);
    slave_mode_i = 1'b1;
    cyc(1);
    chk("R7 no done", done_o, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule